// File: doc/BRIEF.md
# Ethernet MAC Interrupt and Control Register Block

This block is the software-visible control front end of a small Ethernet MAC on a 32-bit memory-mapped bus. It keeps the interrupt status and mask, the receive and transmit control words, the transmit start threshold, the management-interface control, clock divider and transmit data, and the 48-bit station address. It combines status and mask into one level interrupt line. It also sends the control values and single-cycle strobes to the packet datapaths, which sit outside this block.

The datapaths and the management serial engine report what happens through a vector of event pulses. Each pulse sets one status bit. Some register writes have side effects beyond storing a value. Acknowledging the transmit-error interrupt also flushes the transmit FIFO. Writing the receive control word with its flush bit set empties the receive queue. Writing the kick register starts a transmission. The management start bit never reads back as busy.

The bus carries a word address, equal to the byte offset divided by four. Reads are registered: the data for a read request appears on the cycle after it and stays there until the next read. A status event and an acknowledge in the same cycle are resolved in favour of the event.

Top module: `enet_regs_top`

## Requirements
- R1: After a synchronous reset the registers hold these values: interrupt status 0x00, interrupt mask 0x7F, receive control 0x08, transmit control 0x00, threshold 0x3F, management control 0x00, management divider 0x80, management transmit data 0x00 and station address 0. The interrupt line and all three strobes are low.
- R2: The interrupt line is a register equal to the OR of (status AND mask). It reflects each status or mask change in the same cycle as the register that changed.
- R3: The status bits are: bit0 receive, bit1 transmit error, bit2 transmit empty, bit3 FIFO overrun, bit4 receive error, bit5 management done, bit6 PHY. A write to byte offset 0x00 clears each status bit that is 1 in the written data. A read of 0x00 returns the raw status, unmasked.
- R4: A write to 0x00 with data bit1 set makes the transmit-flush strobe high for exactly one cycle. A write to 0x00 with bit1 clear leaves the strobe low.
- R5: A write to receive control (0x08) stores the value. If data bit4 is set, the receive-flush strobe goes high for exactly one cycle. Otherwise the strobe stays low.
- R6: An event pulse on bit k of the event input sets status bit k. When an event and an acknowledge hit the same bit in one cycle, the bit ends set. Acknowledged bits with no event clear in that same cycle.
- R7: A write to management control (0x20) stores the low 8 bits with bit0 (start) forced to 0, both in the register and on the output.
- R8: A write to management transmit data (0x2C) keeps only data bits 7:0.
- R9: A write to 0x14 sets address bytes 0 to 3 from data bits 31:0, least significant byte first. A write to 0x18 sets bytes 4 and 5 from data bits 15:0. The station address output is {byte5, ..., byte0}. A read of 0x18 returns bytes 5:4 in bits 15:0 and zero above.
- R10: A write to 0x38 with data bit0 set makes the transmit-now strobe high for exactly one cycle. With bit0 clear the strobe stays low. Reads of 0x10, 0x28, 0x38 and 0x3C return 0.
- R11: Reads of 0x34 return the receive packet count input and reads of 0x30 return the management receive data input. Writes to these two offsets change nothing.
- R12: Mask (0x04, 7 bits), transmit control (0x0C, 8 bits), threshold (0x1C, 6 bits) and divider (0x24, 8 bits) store the written data truncated to their widths. They read back zero-extended and drive their outputs.
- R13: The read data updates only on the cycle after a read request. It holds its value while no read is requested, even when the register it came from is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write request |
| bus_rd_en | input | 1 | Read request |
| bus_waddr | input | 4 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 7 | Status event pulses from datapaths |
| rx_pkt_count | input | 6 | Receive packet count, read at 0x34 |
| mii_rxd_in | input | 8 | Management receive data, read at 0x30 |
| irq | output | 1 | Level interrupt |
| rx_ctrl | output | 8 | Receive control word |
| tx_ctrl | output | 8 | Transmit control word |
| tx_thresh | output | 6 | Transmit start threshold |
| mii_ctrl | output | 8 | Management control word |
| mii_div | output | 8 | Management clock divider |
| mii_txd | output | 8 | Management transmit data |
| station_addr | output | 48 | Station MAC address |
| tx_fifo_flush | output | 1 | One-cycle transmit FIFO flush strobe |
| rx_fifo_reset | output | 1 | One-cycle receive queue reset strobe |
| tx_send_now | output | 1 | One-cycle transmit-now strobe |

## Verification
Assertions check on every cycle that:
- the interrupt line matches status AND mask;
- acknowledged bits clear unless an event sets them in the same cycle;
- every event bit lands in status;
- each strobe follows only a write carrying its trigger bit;
- the management start bit and transmit data are masked on store;
- reserved reads return zero;
- read data holds between reads.

Only the bench scenarios can show the rest:
- the reset values;
- that a strobe lasts exactly one cycle and stays low for a write without its trigger bit;
- the byte order of the station address;
- the pass-through of the read-only inputs;
- that writes to read-only offsets leave the read-back unchanged.

// File: rtl/enet_regs_pkg.sv
package enet_regs_pkg;
  // Word indices (byte offset / 4)
  localparam int WI_STATUS  = 0;
  localparam int WI_MASK    = 1;
  localparam int WI_RXCTL   = 2;
  localparam int WI_TXCTL   = 3;
  localparam int WI_DATA    = 4;
  localparam int WI_MACLO   = 5;
  localparam int WI_MACHI   = 6;
  localparam int WI_THRESH  = 7;
  localparam int WI_MIICTL  = 8;
  localparam int WI_MIIDIV  = 9;
  localparam int WI_MIIADR  = 10;
  localparam int WI_MIITXD  = 11;
  localparam int WI_MIIRXD  = 12;
  localparam int WI_PKTCNT  = 13;
  localparam int WI_KICK    = 14;
  localparam int WI_STAMP   = 15;

  // Bit positions with side effects
  localparam int TXERR_BIT     = 1;
  localparam int RX_FLUSH_BIT  = 4;
  localparam int MII_START_BIT = 0;
  localparam int KICK_BIT      = 0;

  // Reset values
  localparam int RXCTL_RST  = 'h08;
  localparam int MIIDIV_RST = 'h80;
endpackage

// File: rtl/enet_irq_unit.sv
module enet_irq_unit #(
  parameter int INT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_we,
  input  logic             mask_we,
  input  logic [INT_W-1:0] wdata,
  input  logic [INT_W-1:0] evt_set,
  output logic [INT_W-1:0] status_o,
  output logic [INT_W-1:0] mask_o,
  output logic             irq_o
);
  logic [INT_W-1:0] status_q, status_d;
  logic [INT_W-1:0] mask_q, mask_d;
  logic [INT_W-1:0] clr_vec;
  logic             irq_q;

  always_comb begin
    clr_vec  = ack_we ? wdata : '0;
    status_d = (status_q & ~clr_vec) | evt_set;
    mask_d   = mask_we ? wdata : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '1;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
      irq_q    <= |(status_d & mask_d);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(status_q & mask_q)); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> ((status_q & $past(wdata & ~evt_set)) == '0)); // R3

  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
    (evt_set != '0) |=> ((status_q & $past(evt_set)) == $past(evt_set))); // R6
endmodule

// File: rtl/enet_ctrl_bank.sv
module enet_ctrl_bank
  import enet_regs_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CTRL_W    = 8,
  parameter int THR_W     = 6,
  parameter int MII_W     = 8,
  parameter int MAC_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we_ack,
  input  logic                   we_rxctl,
  input  logic                   we_txctl,
  input  logic                   we_thr,
  input  logic                   we_miictl,
  input  logic                   we_miidiv,
  input  logic                   we_miitxd,
  input  logic                   we_maclo,
  input  logic                   we_machi,
  input  logic                   we_kick,
  input  logic [DATA_W-1:0]      wdata,
  output logic [CTRL_W-1:0]      rx_ctrl,
  output logic [CTRL_W-1:0]      tx_ctrl,
  output logic [THR_W-1:0]       tx_thresh,
  output logic [MII_W-1:0]       mii_ctrl,
  output logic [MII_W-1:0]       mii_div,
  output logic [MII_W-1:0]       mii_txd,
  output logic [8*MAC_BYTES-1:0] station_addr,
  output logic                   tx_fifo_flush,
  output logic                   rx_fifo_reset,
  output logic                   tx_send_now
);
  localparam int LO_BYTES = 4;

  logic [CTRL_W-1:0] rxc_q, txc_q;
  logic [THR_W-1:0]  thr_q;
  logic [MII_W-1:0]  mctl_q, mdiv_q, mtxd_q;
  logic              flush_q, rxrst_q, kick_q;
  logic [MII_W-1:0]  mctl_wr;

  always_comb begin
    mctl_wr = wdata[MII_W-1:0];
    mctl_wr[MII_START_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxc_q   <= CTRL_W'(RXCTL_RST);
      txc_q   <= '0;
      thr_q   <= '1;
      mctl_q  <= '0;
      mdiv_q  <= MII_W'(MIIDIV_RST);
      mtxd_q  <= '0;
      flush_q <= 1'b0;
      rxrst_q <= 1'b0;
      kick_q  <= 1'b0;
    end else begin
      if (we_rxctl)  rxc_q  <= wdata[CTRL_W-1:0];
      if (we_txctl)  txc_q  <= wdata[CTRL_W-1:0];
      if (we_thr)    thr_q  <= wdata[THR_W-1:0];
      if (we_miictl) mctl_q <= mctl_wr;
      if (we_miidiv) mdiv_q <= wdata[MII_W-1:0];
      if (we_miitxd) mtxd_q <= wdata[MII_W-1:0];
      flush_q <= we_ack   & wdata[TXERR_BIT];
      rxrst_q <= we_rxctl & wdata[RX_FLUSH_BIT];
      kick_q  <= we_kick  & wdata[KICK_BIT];
    end
  end

  // Station address bytes: low word holds bytes 0..3, high word the rest
  for (genvar b = 0; b < MAC_BYTES; b++) begin : g_mac
    localparam int SRC_LSB = (b < LO_BYTES) ? 8*b : 8*(b - LO_BYTES);
    logic       byte_we;
    logic [7:0] byte_q;
    assign byte_we = (b < LO_BYTES) ? we_maclo : we_machi;
    always_ff @(posedge clk) begin
      if (rst)          byte_q <= '0;
      else if (byte_we) byte_q <= wdata[SRC_LSB +: 8];
    end
    assign station_addr[8*b +: 8] = byte_q;
  end

  assign rx_ctrl       = rxc_q;
  assign tx_ctrl       = txc_q;
  assign tx_thresh     = thr_q;
  assign mii_ctrl      = mctl_q;
  assign mii_div       = mdiv_q;
  assign mii_txd       = mtxd_q;
  assign tx_fifo_flush = flush_q;
  assign rx_fifo_reset = rxrst_q;
  assign tx_send_now   = kick_q;

  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
    tx_fifo_flush |-> $past(we_ack && wdata[TXERR_BIT])); // R4

  AST_RXRST_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rx_fifo_reset |-> $past(we_rxctl && wdata[RX_FLUSH_BIT])); // R5

  AST_MII_START_DONE: assert property (@(posedge clk) disable iff (rst)
    we_miictl |=> (mii_ctrl[MII_START_BIT] == 1'b0 &&
                   mii_ctrl[MII_W-1:1] == $past(wdata[MII_W-1:1]))); // R7

  AST_MTXD_LOW: assert property (@(posedge clk) disable iff (rst)
    we_miitxd |=> (mii_txd == $past(wdata[MII_W-1:0]))); // R8

  AST_KICK_CAUSE: assert property (@(posedge clk) disable iff (rst)
    tx_send_now |-> $past(we_kick && wdata[KICK_BIT])); // R10
endmodule

// File: rtl/enet_read_mux.sv
module enet_read_mux
  import enet_regs_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 4,
  parameter int INT_W     = 7,
  parameter int CTRL_W    = 8,
  parameter int THR_W     = 6,
  parameter int MII_W     = 8,
  parameter int CNT_W     = 6,
  parameter int MAC_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en,
  input  logic [IDX_W-1:0]       wsel,
  input  logic [INT_W-1:0]       status,
  input  logic [INT_W-1:0]       mask,
  input  logic [CTRL_W-1:0]      rx_ctrl,
  input  logic [CTRL_W-1:0]      tx_ctrl,
  input  logic [THR_W-1:0]       tx_thresh,
  input  logic [MII_W-1:0]       mii_ctrl,
  input  logic [MII_W-1:0]       mii_div,
  input  logic [MII_W-1:0]       mii_txd,
  input  logic [MII_W-1:0]       mii_rxd,
  input  logic [CNT_W-1:0]       pkt_count,
  input  logic [8*MAC_BYTES-1:0] station_addr,
  output logic [DATA_W-1:0]      rdata
);
  localparam int LO_W = 32;
  localparam int HI_W = 8*MAC_BYTES - LO_W;

  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    case (wsel)
      IDX_W'(WI_STATUS): rd_val = DATA_W'(status);
      IDX_W'(WI_MASK):   rd_val = DATA_W'(mask);
      IDX_W'(WI_RXCTL):  rd_val = DATA_W'(rx_ctrl);
      IDX_W'(WI_TXCTL):  rd_val = DATA_W'(tx_ctrl);
      IDX_W'(WI_MACLO):  rd_val = DATA_W'(station_addr[LO_W-1:0]);
      IDX_W'(WI_MACHI):  rd_val = DATA_W'(station_addr[LO_W +: HI_W]);
      IDX_W'(WI_THRESH): rd_val = DATA_W'(tx_thresh);
      IDX_W'(WI_MIICTL): rd_val = DATA_W'(mii_ctrl);
      IDX_W'(WI_MIIDIV): rd_val = DATA_W'(mii_div);
      IDX_W'(WI_MIITXD): rd_val = DATA_W'(mii_txd);
      IDX_W'(WI_MIIRXD): rd_val = DATA_W'(mii_rxd);
      IDX_W'(WI_PKTCNT): rd_val = DATA_W'(pkt_count);
      default:           rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_val;
  end

  assign rdata = rdata_q;

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (wsel == IDX_W'(WI_DATA) || wsel == IDX_W'(WI_MIIADR) ||
               wsel == IDX_W'(WI_KICK) || wsel == IDX_W'(WI_STAMP)))
    |=> (rdata == '0)); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R13
endmodule

// File: rtl/enet_regs_top.sv
module enet_regs_top
  import enet_regs_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 4,
  parameter int INT_W     = 7,
  parameter int CTRL_W    = 8,
  parameter int THR_W     = 6,
  parameter int MII_W     = 8,
  parameter int CNT_W     = 6,
  parameter int MAC_BYTES = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr_en,
  input  logic                   bus_rd_en,
  input  logic [IDX_W-1:0]       bus_waddr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [INT_W-1:0]       evt_set,
  input  logic [CNT_W-1:0]       rx_pkt_count,
  input  logic [MII_W-1:0]       mii_rxd_in,
  output logic                   irq,
  output logic [CTRL_W-1:0]      rx_ctrl,
  output logic [CTRL_W-1:0]      tx_ctrl,
  output logic [THR_W-1:0]       tx_thresh,
  output logic [MII_W-1:0]       mii_ctrl,
  output logic [MII_W-1:0]       mii_div,
  output logic [MII_W-1:0]       mii_txd,
  output logic [8*MAC_BYTES-1:0] station_addr,
  output logic                   tx_fifo_flush,
  output logic                   rx_fifo_reset,
  output logic                   tx_send_now
);
  logic we_ack, we_mask, we_rxctl, we_txctl, we_thr;
  logic we_miictl, we_miidiv, we_miitxd, we_maclo, we_machi, we_kick;
  logic [INT_W-1:0] status_w, mask_w;

  assign we_ack    = bus_wr_en && (bus_waddr == IDX_W'(WI_STATUS));
  assign we_mask   = bus_wr_en && (bus_waddr == IDX_W'(WI_MASK));
  assign we_rxctl  = bus_wr_en && (bus_waddr == IDX_W'(WI_RXCTL));
  assign we_txctl  = bus_wr_en && (bus_waddr == IDX_W'(WI_TXCTL));
  assign we_maclo  = bus_wr_en && (bus_waddr == IDX_W'(WI_MACLO));
  assign we_machi  = bus_wr_en && (bus_waddr == IDX_W'(WI_MACHI));
  assign we_thr    = bus_wr_en && (bus_waddr == IDX_W'(WI_THRESH));
  assign we_miictl = bus_wr_en && (bus_waddr == IDX_W'(WI_MIICTL));
  assign we_miidiv = bus_wr_en && (bus_waddr == IDX_W'(WI_MIIDIV));
  assign we_miitxd = bus_wr_en && (bus_waddr == IDX_W'(WI_MIITXD));
  assign we_kick   = bus_wr_en && (bus_waddr == IDX_W'(WI_KICK));

  enet_irq_unit #(.INT_W(INT_W)) irq_u (
    .clk      (clk),
    .rst      (rst),
    .ack_we   (we_ack),
    .mask_we  (we_mask),
    .wdata    (bus_wdata[INT_W-1:0]),
    .evt_set  (evt_set),
    .status_o (status_w),
    .mask_o   (mask_w),
    .irq_o    (irq)
  );

  enet_ctrl_bank #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .THR_W(THR_W),
    .MII_W(MII_W), .MAC_BYTES(MAC_BYTES)
  ) ctrl_u (
    .clk           (clk),
    .rst           (rst),
    .we_ack        (we_ack),
    .we_rxctl      (we_rxctl),
    .we_txctl      (we_txctl),
    .we_thr        (we_thr),
    .we_miictl     (we_miictl),
    .we_miidiv     (we_miidiv),
    .we_miitxd     (we_miitxd),
    .we_maclo      (we_maclo),
    .we_machi      (we_machi),
    .we_kick       (we_kick),
    .wdata         (bus_wdata),
    .rx_ctrl       (rx_ctrl),
    .tx_ctrl       (tx_ctrl),
    .tx_thresh     (tx_thresh),
    .mii_ctrl      (mii_ctrl),
    .mii_div       (mii_div),
    .mii_txd       (mii_txd),
    .station_addr  (station_addr),
    .tx_fifo_flush (tx_fifo_flush),
    .rx_fifo_reset (rx_fifo_reset),
    .tx_send_now   (tx_send_now)
  );

  enet_read_mux #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .INT_W(INT_W), .CTRL_W(CTRL_W),
    .THR_W(THR_W), .MII_W(MII_W), .CNT_W(CNT_W), .MAC_BYTES(MAC_BYTES)
  ) rd_u (
    .clk          (clk),
    .rst          (rst),
    .rd_en        (bus_rd_en),
    .wsel         (bus_waddr),
    .status       (status_w),
    .mask         (mask_w),
    .rx_ctrl      (rx_ctrl),
    .tx_ctrl      (tx_ctrl),
    .tx_thresh    (tx_thresh),
    .mii_ctrl     (mii_ctrl),
    .mii_div      (mii_div),
    .mii_txd      (mii_txd),
    .mii_rxd      (mii_rxd_in),
    .pkt_count    (rx_pkt_count),
    .station_addr (station_addr),
    .rdata        (bus_rdata)
  );
endmodule

// File: tb/enet_regs_top_tb.sv
module enet_regs_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [3:0]  bus_waddr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  evt_set = '0;
  logic [5:0]  rx_pkt_count = '0;
  logic [7:0]  mii_rxd_in = '0;
  logic        irq;
  logic [7:0]  rx_ctrl, tx_ctrl, mii_ctrl, mii_div, mii_txd;
  logic [5:0]  tx_thresh;
  logic [47:0] station_addr;
  logic        tx_fifo_flush, rx_fifo_reset, tx_send_now;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  enet_regs_top dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .rx_pkt_count(rx_pkt_count), .mii_rxd_in(mii_rxd_in),
    .irq(irq), .rx_ctrl(rx_ctrl), .tx_ctrl(tx_ctrl), .tx_thresh(tx_thresh),
    .mii_ctrl(mii_ctrl), .mii_div(mii_div), .mii_txd(mii_txd),
    .station_addr(station_addr), .tx_fifo_flush(tx_fifo_flush),
    .rx_fifo_reset(rx_fifo_reset), .tx_send_now(tx_send_now)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_waddr = ofs[5:2]; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] ofs, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_waddr = ofs[5:2];
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [6:0] v);
    @(negedge clk);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
  endtask

  task automatic t_reset;
    logic [31:0] r;
    chk("R1", "irq", irq, 0);
    chk("R1", "strobes", {tx_fifo_flush, rx_fifo_reset, tx_send_now}, 0);
    bus_read(8'h00, r); chk("R1", "status", r, 32'h00);
    bus_read(8'h04, r); chk("R1", "mask", r, 32'h7F);
    bus_read(8'h08, r); chk("R1", "rx ctrl", r, 32'h08);
    bus_read(8'h0C, r); chk("R1", "tx ctrl", r, 32'h00);
    bus_read(8'h1C, r); chk("R1", "thresh", r, 32'h3F);
    bus_read(8'h20, r); chk("R1", "mii ctrl", r, 32'h00);
    bus_read(8'h24, r); chk("R1", "mii div", r, 32'h80);
    bus_read(8'h2C, r); chk("R1", "mii txd", r, 32'h00);
    chk("R1", "station addr", station_addr, 0);
  endtask

  task automatic t_event_ack;
    logic [31:0] r;
    pulse_evt(7'h01);
    chk("R2", "irq after rx event", irq, 1);
    bus_read(8'h00, r); chk("R3", "raw status bit0", r, 32'h01);
    bus_write(8'h00, 32'h0000_0001);
    chk("R3", "irq after ack", irq, 0);
    chk("R4", "no flush without bit1", tx_fifo_flush, 0);
    bus_read(8'h00, r); chk("R3", "status after ack", r, 32'h00);
  endtask

  task automatic t_txerr_flush;
    logic [31:0] r;
    pulse_evt(7'h02);
    bus_read(8'h00, r); chk("R3", "tx error bit1", r, 32'h02);
    bus_write(8'h00, 32'h0000_0002);
    chk("R4", "flush pulse high", tx_fifo_flush, 1);
    @(negedge clk);
    chk("R4", "flush pulse one cycle", tx_fifo_flush, 0);
    bus_read(8'h00, r); chk("R4", "status cleared", r, 32'h00);
  endtask

  task automatic t_mask;
    logic [31:0] r;
    bus_write(8'h04, 32'hFFFF_FF00);
    pulse_evt(7'h40);
    chk("R2", "masked irq low", irq, 0);
    bus_read(8'h00, r); chk("R3", "raw phy bit6", r, 32'h40);
    bus_write(8'h04, 32'h0000_0040);
    chk("R2", "irq rises on mask write", irq, 1);
    bus_read(8'h04, r); chk("R12", "mask readback", r, 32'h40);
    bus_write(8'h00, 32'h0000_0040);
    chk("R2", "irq low after ack", irq, 0);
    bus_write(8'h04, 32'h0000_007F);
  endtask

  task automatic t_set_wins;
    logic [31:0] r;
    pulse_evt(7'h01);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_waddr = 4'd0; bus_wdata = 32'h09; evt_set = 7'h08;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_wdata = '0; evt_set = '0;
    bus_read(8'h00, r); chk("R6", "set beats clear", r, 32'h08);
    chk("R6", "irq stays high", irq, 1);
    bus_write(8'h00, 32'h7F);
    bus_read(8'h00, r); chk("R6", "cleared afterwards", r, 32'h00);
  endtask

  task automatic t_rx_reset;
    bus_write(8'h08, 32'h0000_0011);
    chk("R5", "rx reset pulse", rx_fifo_reset, 1);
    chk("R5", "rx ctrl stored", rx_ctrl, 8'h11);
    @(negedge clk);
    chk("R5", "rx reset one cycle", rx_fifo_reset, 0);
    bus_write(8'h08, 32'h0000_0001);
    chk("R5", "no rx reset without bit4", rx_fifo_reset, 0);
  endtask

  task automatic t_mii;
    logic [31:0] r;
    bus_write(8'h20, 32'h0000_01A5);
    bus_read(8'h20, r); chk("R7", "start bit reads done", r, 32'hA4);
    chk("R7", "mii ctrl output", mii_ctrl, 8'hA4);
    bus_write(8'h2C, 32'h1234_ABCD);
    bus_read(8'h2C, r); chk("R8", "txd low byte", r, 32'hCD);
    chk("R8", "txd output", mii_txd, 8'hCD);
  endtask

  task automatic t_station;
    logic [31:0] r;
    bus_write(8'h14, 32'h4433_2211);
    bus_write(8'h18, 32'hFFFF_6655);
    chk("R9", "station addr", station_addr, 48'h6655_4433_2211);
    bus_read(8'h14, r); chk("R9", "low word", r, 32'h4433_2211);
    bus_read(8'h18, r); chk("R9", "high word", r, 32'h0000_6655);
  endtask

  task automatic t_kick_reserved;
    logic [31:0] r;
    bus_write(8'h38, 32'h1);
    chk("R10", "send strobe", tx_send_now, 1);
    @(negedge clk);
    chk("R10", "send one cycle", tx_send_now, 0);
    bus_write(8'h38, 32'h2);
    chk("R10", "no send without bit0", tx_send_now, 0);
    bus_read(8'h38, r); chk("R10", "read 0x38", r, 0);
    bus_read(8'h10, r); chk("R10", "read 0x10", r, 0);
    bus_read(8'h28, r); chk("R10", "read 0x28", r, 0);
    bus_read(8'h3C, r); chk("R10", "read 0x3C", r, 0);
  endtask

  task automatic t_readonly;
    logic [31:0] r;
    rx_pkt_count = 6'd5; mii_rxd_in = 8'h3C;
    bus_write(8'h34, 32'h1F);
    bus_write(8'h30, 32'hEE);
    bus_read(8'h34, r); chk("R11", "packet count", r, 32'h5);
    bus_read(8'h30, r); chk("R11", "mii rx data", r, 32'h3C);
  endtask

  task automatic t_widths_hold;
    logic [31:0] r;
    bus_write(8'h1C, 32'hFF);
    bus_read(8'h1C, r); chk("R12", "threshold 6 bits", r, 32'h3F);
    bus_write(8'h1C, 32'h12);
    chk("R12", "threshold output", tx_thresh, 6'h12);
    bus_write(8'h0C, 32'h1FF);
    bus_read(8'h0C, r); chk("R12", "tx ctrl 8 bits", r, 32'hFF);
    bus_write(8'h24, 32'h312);
    bus_read(8'h24, r); chk("R12", "divider", r, 32'h12);
    chk("R12", "divider output", mii_div, 8'h12);
    bus_write(8'h24, 32'h55);
    @(negedge clk);
    chk("R13", "rdata holds without read", bus_rdata, 32'h12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_event_ack();
    t_txerr_flush();
    t_mask();
    t_set_wins();
    t_rx_reset();
    t_mii();
    t_station();
    t_kick_reserved();
    t_readonly();
    t_widths_hold();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule